// File: doc/BRIEF.md
# Two-Domain Reset Sequencer

This block turns a board-level reset pin and a clock-generator lock flag into two ordered, active-high reset outputs. The first output resets the clock generator and lives in the external (reference) clock domain. The second resets the rest of the system and lives in the generated clock domain. The system reset is only released once three things have happened in order: the generator reset has been released, the generator has reported lock, and a further delay has elapsed in the generated domain.

Every asynchronous input is brought into the domain that uses it through a two-flop synchroniser before any decision is made on it. Each output comes from a small delay stage: a counter that is cleared while its hold condition is present, counts up once the condition is gone, and releases its reset when it reaches all ones. The generator reset state is also carried into the generated domain, so the system stage restarts whenever the generator is being reset. The polarity of the board reset pin and the widths of both counters are parameters.

Top module: `dual_rst_sequencer`

## Requirements
- R1: While the board reset is active (pin low when BOARD_RST_ACTIVE_LOW=1, high when it is 0), `pll_reset_o` is 1; it goes to 1 on the third `clk_ext` rising edge that samples the pin active.
- R2: After the board reset becomes inactive, `pll_reset_o` returns to 0 on the (2^PLL_HOLD_W + 2)-th `clk_ext` rising edge that samples the pin inactive (6th edge for width 2).
- R3: `sys_reset_o` stays 1 for as long as `lock_i` is 0, including after `pll_reset_o` has been released.
- R4: With `pll_reset_o` already released, `sys_reset_o` returns to 0 on the (2^SYS_HOLD_W + 2)-th `clk_pll` rising edge that samples `lock_i` at 1 (6th edge for width 2).
- R5: When the board reset becomes active during normal running, `sys_reset_o` goes to 1 on the third `clk_pll` edge that samples it, the same edge as `pll_reset_o` when both clocks are one clock.
- R6: After the board reset is released with `lock_i` held at 1, `sys_reset_o` returns to 0 (2^SYS_HOLD_W + 2) `clk_pll` edges after `pll_reset_o` fell (12 edges after the pin went inactive for a common clock and width 2).
- R7: Both outputs are active-high, and whenever the generator reset is seen active in the generated domain, `sys_reset_o` is 1 from the next `clk_pll` edge.
- R8: If `lock_i` falls while running, `sys_reset_o` goes to 1 on the third `clk_pll` edge that samples it low while `pll_reset_o` stays 0, and the full system delay of R4 is run again when lock returns.
- R9: With BOARD_RST_ACTIVE_LOW=0 and the pin driven with the opposite level, both outputs follow exactly the same sequence as with the default polarity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ext | input | 1 | External reference clock; domain of the generator reset |
| clk_pll | input | 1 | Generated clock; domain of the system reset |
| lock_i | input | 1 | Lock flag from the clock generator, asynchronous |
| board_rst_i | input | 1 | Board reset pin, asynchronous, polarity set by BOARD_RST_ACTIVE_LOW |
| pll_reset_o | output | 1 | Active-high reset to the clock generator, `clk_ext` domain |
| sys_reset_o | output | 1 | Active-high system reset, `clk_pll` domain |

## Verification
The sequencer is driven through a power-up pattern with the board reset held and lock absent, then a pin release without lock, which separates the generator delay from the lock gate, then lock arriving, which measures the system delay on its own. A board reset pulse during running shows whether both outputs assert together after synchronisation, and its release with lock held shows that the system delay is chained behind the generator delay rather than started by the pin. A lock drop and return during running shows that lock alone re-arms the system stage without touching the generator reset, and a second instance with the opposite pin polarity must reproduce every step.

// File: rtl/dual_rst_pkg.sv
`timescale 1ns/1ps
package dual_rst_pkg;
  // Depth of every clock-domain-crossing synchroniser in the block.
  localparam int unsigned SYNC_DEPTH = 2;
  typedef logic [SYNC_DEPTH-1:0] sync_vec_t;
endpackage

// File: rtl/dual_rst_sync.sv
`timescale 1ns/1ps
module dual_rst_sync
  import dual_rst_pkg::*;
(
  input  logic clk,
  input  logic d_async,
  output logic q_sync
);
  sync_vec_t stage_q;
  sync_vec_t stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[SYNC_DEPTH-2:0], d_async};
  end

  always_ff @(posedge clk) begin
    stage_q <= stage_nxt;
  end

  assign q_sync = stage_q[SYNC_DEPTH-1];
endmodule

// File: rtl/dual_rst_delay.sv
`timescale 1ns/1ps
module dual_rst_delay #(
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic hold_i,
  output logic rst_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             rel_q;
  logic             rel_nxt;

  // Counter runs only when the hold condition is gone and it has not saturated.
  always_comb begin
    cnt_en  = !hold_i && (cnt_q != CNT_MAX);
    cnt_nxt = cnt_q;
    if (hold_i) begin
      cnt_nxt = '0;
    end else if (cnt_en) begin
      cnt_nxt = cnt_q + 1'b1;
    end
    rel_nxt = !hold_i && (cnt_q == CNT_MAX);
  end

  // Zero state of both registers means "reset asserted".
  always_ff @(posedge clk) begin
    cnt_q <= cnt_nxt;
    rel_q <= rel_nxt;
  end

  assign rst_o = !rel_q;

  AST_HOLD_FORCES_RESET: assert property (@(posedge clk)
    hold_i |=> rst_o);  // R1

  AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk)
    $fell(rst_o) |-> (!hold_i && !$past(hold_i)));  // R2

  AST_RELEASED_STAYS: assert property (@(posedge clk) disable iff (hold_i)
    !rst_o |=> !rst_o);  // R4
endmodule

// File: rtl/dual_rst_sequencer.sv
`timescale 1ns/1ps
module dual_rst_sequencer #(
  parameter int unsigned PLL_HOLD_W           = 2,
  parameter int unsigned SYS_HOLD_W           = 2,
  parameter bit          BOARD_RST_ACTIVE_LOW = 1'b1
) (
  input  logic clk_ext,
  input  logic clk_pll,
  input  logic lock_i,
  input  logic board_rst_i,
  output logic pll_reset_o,
  output logic sys_reset_o
);
  logic board_req_raw;
  logic board_req_ext;
  logic board_req_pll;
  logic lock_pll;
  logic pll_rst_pll;
  logic sys_hold;

  // Normalise the pin to an active-high request.
  generate
    if (BOARD_RST_ACTIVE_LOW) begin : g_pin_low
      assign board_req_raw = !board_rst_i;
    end else begin : g_pin_high
      assign board_req_raw = board_rst_i;
    end
  endgenerate

  // ---------------- external clock domain ----------------
  dual_rst_sync u_sync_board_ext (
    .clk     (clk_ext),
    .d_async (board_req_raw),
    .q_sync  (board_req_ext)
  );

  dual_rst_delay #(.CNT_W(PLL_HOLD_W)) u_pll_delay (
    .clk    (clk_ext),
    .hold_i (board_req_ext),
    .rst_o  (pll_reset_o)
  );

  // ---------------- generated clock domain ----------------
  dual_rst_sync u_sync_board_pll (
    .clk     (clk_pll),
    .d_async (board_req_raw),
    .q_sync  (board_req_pll)
  );

  dual_rst_sync u_sync_lock (
    .clk     (clk_pll),
    .d_async (lock_i),
    .q_sync  (lock_pll)
  );

  dual_rst_sync u_sync_pllrst (
    .clk     (clk_pll),
    .d_async (pll_reset_o),
    .q_sync  (pll_rst_pll)
  );

  always_comb begin
    sys_hold = board_req_pll || pll_rst_pll || !lock_pll;
  end

  dual_rst_delay #(.CNT_W(SYS_HOLD_W)) u_sys_delay (
    .clk    (clk_pll),
    .hold_i (sys_hold),
    .rst_o  (sys_reset_o)
  );

  AST_SYS_NEEDS_LOCK: assert property (@(posedge clk_pll)
    !sys_reset_o |-> $past(lock_pll));  // R3

  AST_SYS_NEEDS_PLL_DONE: assert property (@(posedge clk_pll)
    !sys_reset_o |-> $past(!pll_rst_pll));  // R6

  AST_PLL_RST_FORCES_SYS: assert property (@(posedge clk_pll)
    pll_rst_pll |=> sys_reset_o);  // R7

  AST_BOARD_FORCES_SYS: assert property (@(posedge clk_pll)
    board_req_pll |=> sys_reset_o);  // R5
endmodule

// File: tb/dual_rst_sequencer_test.sv
`timescale 1ns/1ps
module dual_rst_sequencer_test;
  logic clk;
  logic lock;
  logic board_n;
  logic board_p;
  logic pll_rst;
  logic sys_rst;
  logic pll_rst_p;
  logic sys_rst_p;
  int   n_checks;
  int   n_fails;
  bit   done;

  typedef struct {
    logic  pll;
    logic  sys;
    string tag_pll;
    string tag_sys;
  } exp_t;
  exp_t sb_q[$];

  assign board_p = ~board_n;

  dual_rst_sequencer #(.PLL_HOLD_W(2), .SYS_HOLD_W(2), .BOARD_RST_ACTIVE_LOW(1'b1)) uut (
    .clk_ext     (clk),
    .clk_pll     (clk),
    .lock_i      (lock),
    .board_rst_i (board_n),
    .pll_reset_o (pll_rst),
    .sys_reset_o (sys_rst)
  );

  dual_rst_sequencer #(.PLL_HOLD_W(2), .SYS_HOLD_W(2), .BOARD_RST_ACTIVE_LOW(1'b0)) uut_pos (
    .clk_ext     (clk),
    .clk_pll     (clk),
    .lock_i      (lock),
    .board_rst_i (board_p),
    .pll_reset_o (pll_rst_p),
    .sys_reset_o (sys_rst_p)
  );

  // 125 MHz
  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Driver: apply inputs 2 ns after an edge; the expectation is for the outputs
  // after the next edge, which samples these inputs.
  task automatic step(input logic lk, input logic rn, input logic ep, input logic es,
                      input string tp, input string ts);
    exp_t it;
    @(posedge clk);
    #2;
    it.pll = ep;
    it.sys = es;
    it.tag_pll = tp;
    it.tag_sys = ts;
    sb_q.push_back(it);
    lock    = lk;
    board_n = rn;
  endtask

  task automatic steps(input int n, input logic lk, input logic rn, input logic ep,
                       input logic es, input string tp, input string ts);
    for (int i = 0; i < n; i++) step(lk, rn, ep, es, tp, ts);
  endtask

  // Monitor: 1 ns after each edge.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag_pll, "pll_reset_o", pll_rst, it.pll);
        check(it.tag_sys, "sys_reset_o", sys_rst, it.sys);
        check("R9", "pll_reset_o active-high pin", pll_rst_p, it.pll);
        check("R9", "sys_reset_o active-high pin", sys_rst_p, it.sys);
        if (pll_rst === 1'b1) check("R7", "sys_reset_o while pll reset", sys_rst, 1'b1);
      end
    end
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    done     = 1'b0;
    lock     = 1'b0;
    board_n  = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    check("R1", "reset state pll_reset_o", pll_rst, 1'b1);
    check("R3", "reset state sys_reset_o", sys_rst, 1'b1);

    // Power-up: pin held, no lock (R1, R3)
    steps(6, 1'b0, 1'b0, 1'b1, 1'b1, "R1", "R3");
    // Pin released without lock: generator reset falls on 6th edge (R2, R3)
    steps(5, 1'b0, 1'b1, 1'b1, 1'b1, "R2", "R3");
    steps(3, 1'b0, 1'b1, 1'b0, 1'b1, "R2", "R3");
    // Lock arrives: system reset falls on 6th edge (R4)
    steps(5, 1'b1, 1'b1, 1'b0, 1'b1, "R4", "R4");
    steps(3, 1'b1, 1'b1, 1'b0, 1'b0, "R4", "R4");
    // Pin asserted while running: both rise on 3rd edge (R1, R5)
    steps(2, 1'b1, 1'b0, 1'b0, 1'b0, "R1", "R5");
    steps(2, 1'b1, 1'b0, 1'b1, 1'b1, "R1", "R5");
    // Pin released with lock held: chained release (R2, R6)
    steps(5, 1'b1, 1'b1, 1'b1, 1'b1, "R2", "R6");
    steps(6, 1'b1, 1'b1, 1'b0, 1'b1, "R2", "R6");
    steps(3, 1'b1, 1'b1, 1'b0, 1'b0, "R6", "R6");
    // Lock lost while running, then regained (R8)
    steps(2, 1'b0, 1'b1, 1'b0, 1'b0, "R8", "R8");
    steps(2, 1'b0, 1'b1, 1'b0, 1'b1, "R8", "R8");
    steps(5, 1'b1, 1'b1, 1'b0, 1'b1, "R8", "R8");
    steps(3, 1'b1, 1'b1, 1'b0, 1'b0, "R8", "R8");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule